// File: doc/BRIEF.md
# Reciprocal Frequency Meter with Ready Strobe

This block measures how fast an external signal toggles by timing a fixed number of its rising edges against a local reference clock (50 MHz in the intended system). All logic runs on the reference clock. The measured signal is never used as a clock: it is sampled as asynchronous data, passed through a two-flop synchronizer, and its rising edges are found by comparing the synchronized level with a one-cycle-delayed copy.

A measurement window opens on the first detected rising edge after reset. It closes on the sixteenth edge after that. The number of reference cycles that elapsed in the window is the result, which is sixteen input periods in reference cycles. It is loaded into a 24-bit output register, and a one-cycle ready strobe is raised in the same cycle. Downstream logic, such as a serial sender, can therefore take each new value the moment it exists, without treating any signal as a clock.

The closing edge of one window is the opening edge of the next, so successive results tile time with no lost cycles. An input that is too slow, or has stopped, drives the cycle counter to its all-ones limit. The block then reports that limit with a ready strobe and waits for a fresh opening edge.

Top module: `freq_meter`

## Requirements
- R1: While reset (active low) is asserted, `periodOut` reads 0 and `ready` is low. After reset, no result appears until a new full window has been timed.
- R2: For a steady input with a period of P reference cycles (P of at least 2), every result reports EDGES*P, which is 16*P by default.
- R3: `ready` is high for exactly one reference cycle per result. `periodOut` takes its new value in that same cycle.
- R4: `periodOut` changes only in a cycle where `ready` is high. It holds its value between results.
- R5: The first result after reset, or after the input resumes following a stall, comes after the 17th rising edge of the input: the opening edge plus 16 more. No partial window is ever reported.
- R6: Consecutive windows abut. For a steady input, the spacing between successive `ready` pulses equals the reported value.
- R7: If no closing edge arrives before the cycle counter reaches 2^CNT_W-1, that all-ones value is reported with `ready`. No further result follows until a new opening edge arrives.
- R8: The result depends only on the rising-edge spacing, not on the duty cycle. A high time of a single reference cycle still measures correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; every flop of the block is clocked by it |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 1 | Raw asynchronous input whose frequency is measured |
| periodOut | output | CNT_W (24) | Reference cycles counted across the last window of EDGES input periods |
| ready | output | 1 | One-cycle strobe marking a newly loaded `periodOut` |

## Verification
The hardest state to reach is the saturation path. The counter must run to its all-ones limit with no closing edge, and the block must then fall back to waiting for an opening edge. With a 24-bit counter this takes millions of cycles, so the bench builds the meter with a 12-bit counter, stops the input right after a normal result, and then waits for the all-ones report. It then checks for a silent idle period and a correct first result once the input restarts. Period changes are handled by discarding the results whose windows straddle the change, then checking both the value and the pulse spacing.

// File: rtl/fm_pkg.sv
package fm_pkg;

  // Strobes from the window control to the counting datapath
  typedef struct packed {
    logic run;      // window open: advance the cycle counter
    logic restart;  // opening edge seen: counter restarts at one
    logic latch;    // window closed: capture count and pulse ready
  } fm_strobe_t;

endpackage

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int EDGES       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       sigIn,
  input  logic       cntMax,
  output fm_strobe_t strobe
);

  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   delayQ;
  logic                   windowOpen;
  logic [EDGE_W-1:0]      edgeCnt;
  logic                   rise;
  logic                   lastEdge;
  logic                   satHit;

  // Synchronizer chain: the raw pin is only ever sampled
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      delayQ <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], sigIn};
      delayQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise     = syncQ[SYNC_STAGES-1] & ~delayQ;
  assign lastEdge = windowOpen && rise && (edgeCnt == LAST_EDGE);
  assign satHit   = windowOpen && cntMax && !lastEdge;

  always_comb begin
    strobe.run     = windowOpen;
    strobe.restart = rise && (!windowOpen || lastEdge);
    strobe.latch   = lastEdge || satHit;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      windowOpen <= 1'b0;
      edgeCnt    <= '0;
    end else if (!windowOpen) begin
      if (rise) begin
        windowOpen <= 1'b1;
        edgeCnt    <= '0;
      end
    end else if (lastEdge) begin
      edgeCnt <= '0;
    end else if (satHit) begin
      windowOpen <= 1'b0;
      edgeCnt    <= '0;
    end else if (rise) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             refClk,
  input  logic             rstN,
  input  fm_strobe_t       strobe,
  output logic             cntMax,
  output logic [CNT_W-1:0] periodOut,
  output logic             ready
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cycleCnt;

  assign cntMax = (cycleCnt == CNT_TOP);

  // Cycle counter: starts at one on the opening edge, saturates at the top
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobe.restart) begin
      cycleCnt <= CNT_W'(1);
    end else if (strobe.run && !cntMax) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  // Result register and its strobe change on the same edge
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      periodOut <= '0;
      ready     <= 1'b0;
    end else begin
      ready <= strobe.latch;
      if (strobe.latch) periodOut <= cycleCnt;
    end
  end

endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int EDGES = 16
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             sigIn,
  output logic [CNT_W-1:0] periodOut,
  output logic             ready
);

  fm_strobe_t strobe;
  logic       cntMax;

  fm_ctrl #(.EDGES(EDGES), .SYNC_STAGES(2)) u_ctrl (
    .refClk (refClk),
    .rstN   (rstN),
    .sigIn  (sigIn),
    .cntMax (cntMax),
    .strobe (strobe)
  );

  fm_datapath #(.CNT_W(CNT_W)) u_dp (
    .refClk    (refClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cntMax    (cntMax),
    .periodOut (periodOut),
    .ready     (ready)
  );

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int CNT_W = 24,
  parameter int EDGES = 16
) (
  input logic             refClk,
  input logic             rstN,
  input logic [CNT_W-1:0] periodOut,
  input logic             ready
);

  localparam logic [CNT_W:0] GAP_TOP = {(CNT_W+1){1'b1}};

  // Cycles since the previous ready pulse (or since reset), saturating
  logic [CNT_W:0] gapCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                gapCnt <= '0;
    else if (ready)           gapCnt <= (CNT_W+1)'(1);
    else if (gapCnt != GAP_TOP) gapCnt <= gapCnt + 1'b1;
  end

  AST_READY_ONE_CYCLE: assert property (@(posedge refClk) disable iff (!rstN)
    ready |=> !ready);                                              // R3

  AST_OUT_HOLDS: assert property (@(posedge refClk) disable iff (!rstN)
    !ready |-> $stable(periodOut));                                 // R4

  AST_MIN_WINDOW: assert property (@(posedge refClk) disable iff (!rstN)
    ready |-> (periodOut >= CNT_W'(2 * EDGES)));                    // R2

  AST_WINDOWS_FIT_GAP: assert property (@(posedge refClk) disable iff (!rstN)
    ready |-> (gapCnt >= {1'b0, periodOut}));                       // R6

endmodule

bind freq_meter fm_checker #(.CNT_W(CNT_W), .EDGES(EDGES)) u_chk (
  .refClk    (refClk),
  .rstN      (rstN),
  .periodOut (periodOut),
  .ready     (ready)
);

// File: tb/freq_meter_bench.sv
module freq_meter_bench;

  localparam int CLK_PERIOD = 20;
  localparam int TB_CNT_W   = 12;
  localparam int TB_EDGES   = 16;
  localparam int SAT_VALUE  = (1 << TB_CNT_W) - 1;

  // Stimulus table: input period, high time, expected result (cycles)
  localparam int VEC_N = 6;
  localparam int VEC_PER [VEC_N] = '{10, 7, 25, 2, 100, 3};
  localparam int VEC_HI  [VEC_N] = '{5, 3, 1, 1, 50, 2};
  localparam int VEC_EXP [VEC_N] = '{160, 112, 400, 32, 1600, 48};

  logic                refClk = 1'b0;
  logic                rstN   = 1'b0;
  logic                sigIn  = 1'b0;
  logic [TB_CNT_W-1:0] periodOut;
  logic                ready;

  int  tests = 0;
  int  fails = 0;
  int  cycNow = 0;
  bit  waveOn = 1'b0;
  int  wavePer = 10;
  int  waveHi = 5;
  int  phase = 0;
  int  risesDriven = 0;
  int  holdErr = 0;
  int  pulseErr = 0;
  logic [TB_CNT_W-1:0] prevOut = '0;
  logic                prevReady = 1'b0;

  freq_meter #(.CNT_W(TB_CNT_W), .EDGES(TB_EDGES)) u_freq_meter (
    .refClk    (refClk),
    .rstN      (rstN),
    .sigIn     (sigIn),
    .periodOut (periodOut),
    .ready     (ready)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;
  always @(posedge refClk) cycNow <= cycNow + 1;

  // Input waveform generator, driven away from the active edge
  always @(negedge refClk) begin
    if (waveOn) begin
      if (!sigIn && (phase < waveHi)) risesDriven <= risesDriven + 1;
      sigIn <= (phase < waveHi);
      phase <= (phase + 1 >= wavePer) ? 0 : phase + 1;
    end else begin
      sigIn <= 1'b0;
    end
  end

  // Output monitors for R3 and R4
  always @(negedge refClk) begin
    if (rstN) begin
      if (!ready && periodOut != prevOut) holdErr <= holdErr + 1;
      if (ready && prevReady) pulseErr <= pulseErr + 1;
    end
    prevOut   <= periodOut;
    prevReady <= ready;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitReady(input int limit, output int cyc, output bit seen);
    seen = 1'b0;
    cyc  = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge refClk);
      if (ready) begin
        seen = 1'b1;
        cyc  = cycNow;
        return;
      end
    end
  endtask

  task automatic startWave(input int per, input int hi);
    @(negedge refClk);
    wavePer     = per;
    waveHi      = hi;
    phase       = 0;
    risesDriven = 0;
    waveOn      = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int  c0, c1;
    bit  seen;

    // Reset state (R1)
    repeat (4) @(negedge refClk);
    check("R1 periodOut in reset", int'(periodOut), 0);
    check("R1 ready in reset", int'(ready), 0);
    rstN = 1'b1;

    // First window after reset (R5)
    startWave(10, 5);
    waitReady(5000, c0, seen);
    check("R5 first result seen", int'(seen), 1);
    check("R5 rises before first result", risesDriven, 17);
    check("R5 first value", int'(periodOut), 160);

    // Table of periods (R2, R6, R8)
    for (int v = 0; v < VEC_N; v++) begin
      startWave(VEC_PER[v], VEC_HI[v]);
      waitReady(20000, c0, seen);
      waitReady(20000, c0, seen);
      waitReady(20000, c0, seen);
      check("R2 R8 value for period", int'(periodOut), VEC_EXP[v]);
      waitReady(20000, c1, seen);
      check("R6 ready spacing", c1 - c0, VEC_EXP[v]);
    end

    // Reset during a window clears and restarts the count (R1, R5)
    startWave(10, 5);
    repeat (50) @(negedge refClk);
    waveOn = 1'b0;
    rstN   = 1'b0;
    repeat (3) @(negedge refClk);
    check("R1 periodOut after mid-run reset", int'(periodOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge refClk);
    startWave(10, 5);
    waitReady(5000, c0, seen);
    check("R5 rises after mid-run reset", risesDriven, 17);

    // Stalled input saturates (R7)
    waitReady(5000, c0, seen);
    waveOn = 1'b0;
    waitReady(10000, c0, seen);
    check("R7 saturation reported", int'(seen), 1);
    check("R7 saturated value", int'(periodOut), SAT_VALUE);
    waitReady(6000, c0, seen);
    check("R7 no result while idle", int'(seen), 0);
    check("R7 value held while idle", int'(periodOut), SAT_VALUE);

    // Input resumes after a stall (R5, R7)
    startWave(10, 5);
    waitReady(5000, c0, seen);
    check("R7 rises after resume", risesDriven, 17);
    check("R7 value after resume", int'(periodOut), 160);

    // Monitor totals (R3, R4)
    check("R3 ready wider than one cycle", pulseErr, 0);
    check("R4 output changed without ready", holdErr, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule